// File: doc/BRIEF.md
# Line-Range Buffer Transfer Controller

This controller moves fixed-width words ("lines") between a 512-line synchronous buffer RAM and a streaming peer. A 32-bit command word, taken on a one-cycle `cmd_go` pulse, selects one of three operations. Clear parks the block. Read streams a span of RAM lines out to a consumer. Write fills a span of RAM lines from a producer. The span runs from a first index to a last index, both inclusive, and wraps from line 511 back to line 0 when the first index is above the last.

On the read side the controller prefetches one line ahead. The consumer therefore sees valid data, with a start-of-packet flag, before it issues any strobe. The consumer may pace its strobes freely, and the end-of-packet flag marks the last line of the span. On the write side `wr_ready` shows that strobes are being accepted, and `wr_full` reports that the whole span has been written.

Either peer can cut a transfer short with a finish input, which ends it cleanly, or an abort input, which ends it as an error. A strobe in that same cycle still counts. Once a transfer has ended, further strobes never reach the RAM.

Top module: `ram_stream_xfer`

## Requirements
- R1: While reset is held and just after it, `xfer_done`, `xfer_err`, `wr_ready`, `wr_full`, `rd_sop`, `rd_eop` and `mem_en` are all low.
- R2: A command is taken only in a cycle where `cmd_go` is high. The command word carries the first line in bits 8:0, the last line in bits 17:9, the read flag at bit 22, the write flag at bit 23 and the clear flag at bit 24. If more than one flag is set, clear wins over read and read wins over write.
- R3: A transfer covers every line from first to last inclusive, wrapping 511 to 0, so it moves ((last - first) mod 512) + 1 lines. Equal indices move exactly one line.
- R4: The data for the first line appears on `rd_data` with `rd_sop` high two cycles after the read command is taken, before any strobe. After each strobe, the next line is on `rd_data` in the following cycle. `rd_eop` is high while the last line is presented.
- R5: While the consumer leaves idle cycles between strobes, `rd_data` holds the current line and no RAM access is made.
- R6: During a write transfer `wr_ready` is high. Each `wr_strobe` stores `wr_data` into the next line of the span, in ascending and wrapping order.
- R7: Writing the last line of the span raises `wr_full` and `xfer_done`. Both stay high until the next command is taken.
- R8: A finish input on the active side ends the transfer with `xfer_done` high. A strobe in that same cycle is still honoured, and no further line is fetched.
- R9: An abort input on the active side ends the transfer with `xfer_err` high and `xfer_done` low. A strobe in that same cycle is still honoured.
- R10: Strobes after a transfer has ended, or beyond the end of the span, cause no RAM access. RAM lines outside the span keep their contents.
- R11: A clear command takes effect from any state. One cycle later `xfer_done`, `xfer_err`, `wr_ready`, `wr_full` and `rd_sop` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_word | input | 32 | Command: span indices and operation flags |
| cmd_go | input | 1 | One-cycle pulse that takes `cmd_word` |
| xfer_done | output | 1 | Transfer finished normally |
| xfer_err | output | 1 | Transfer ended by an abort |
| mem_en | output | 1 | RAM access enable |
| mem_we | output | 1 | RAM write enable |
| mem_addr | output | 9 | RAM line index |
| mem_wdata | output | DATA_W | Data to RAM |
| mem_rdata | input | DATA_W | Data from RAM, one cycle after an enabled read |
| wr_data | input | DATA_W | Producer data |
| wr_strobe | input | 1 | Producer offers one line |
| wr_finish | input | 1 | Producer ends the transfer |
| wr_abort | input | 1 | Producer ends the transfer with error |
| wr_ready | output | 1 | Write transfer is accepting lines |
| wr_full | output | 1 | Whole span has been written |
| rd_data | output | DATA_W | Line presented to consumer |
| rd_strobe | input | 1 | Consumer takes the presented line |
| rd_finish | input | 1 | Consumer ends the transfer |
| rd_abort | input | 1 | Consumer ends the transfer with error |
| rd_sop | output | 1 | Presented line is the first of the span |
| rd_eop | output | 1 | Presented line is the last of the span |

## Verification
Reads are run over a plain span, a wrapping span, a one-line span and the whole buffer, so the span-length arithmetic is tested at both ends of its range. They are run back to back and with idle gaps, which separates correct prefetch timing from data that only holds while strobes keep coming. Finish and abort are raised together with a mid-span strobe, and extra strobes are sent after the span ends. Counting RAM accesses then shows whether a design stops fetching and writing at the right moment or spills past the span. Writes over wrapping, overlong and cut-short spans are checked against a full shadow of the RAM. A final wrapping read-back confirms both the order of the stored lines and that lines outside each span were left untouched.

// File: rtl/xfer_pkg.sv
`timescale 1ns/1ps
package xfer_pkg;
  localparam int LINE_W    = 9;
  localparam int CMD_W     = 32;
  localparam int F_FIRST   = 0;
  localparam int F_LAST    = F_FIRST + LINE_W;
  localparam int F_STEP    = F_LAST + LINE_W;
  localparam int STEP_W    = 4;
  localparam int B_READ    = F_STEP + STEP_W;
  localparam int B_WRITE   = B_READ + 1;
  localparam int B_CLEAR   = B_WRITE + 1;

  typedef logic [LINE_W-1:0] line_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE_READ, ST_READING, ST_WRITING, ST_ERROR, ST_DONE
  } xfer_state_e;

  typedef enum logic [1:0] {OP_NONE, OP_CLEAR, OP_READ, OP_WRITE} xfer_op_e;

  typedef struct packed {
    xfer_op_e op;
    line_t    first;
    line_t    last;
  } xfer_cmd_t;

  // lines still to move after the first one; wraps modulo the buffer size
  function automatic line_t lines_after_first(line_t first, line_t last);
    return last - first;
  endfunction

  function automatic line_t line_succ(line_t idx);
    return idx + line_t'(1);
  endfunction
endpackage

// File: rtl/xfer_cmd_decode.sv
`timescale 1ns/1ps
module xfer_cmd_decode
  import xfer_pkg::*;
(
  input  logic [CMD_W-1:0] cmd_word,
  input  logic             cmd_go,
  output xfer_cmd_t        cmd,
  output logic             cmd_take
);
  logic unused_fields;
  assign unused_fields = ^{cmd_word[CMD_W-1:B_CLEAR+1], cmd_word[B_READ-1:F_STEP]};

  always_comb begin
    cmd.first = cmd_word[F_FIRST +: LINE_W];
    cmd.last  = cmd_word[F_LAST  +: LINE_W];
    if (cmd_word[B_CLEAR])      cmd.op = OP_CLEAR;
    else if (cmd_word[B_READ])  cmd.op = OP_READ;
    else if (cmd_word[B_WRITE]) cmd.op = OP_WRITE;
    else                        cmd.op = OP_NONE;
    cmd_take = cmd_go && (cmd.op != OP_NONE);
  end
endmodule

// File: rtl/xfer_line_walker.sv
`timescale 1ns/1ps
module xfer_line_walker
  import xfer_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  load,
  input  line_t load_first,
  input  line_t load_last,
  input  logic  addr_inc,
  input  logic  rem_dec,
  output line_t cur_line,
  output logic  at_last
);
  line_t rem_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_line <= '0;
      rem_q    <= '0;
    end else if (load) begin
      cur_line <= load_first;
      rem_q    <= lines_after_first(load_first, load_last);
    end else begin
      if (addr_inc) cur_line <= line_succ(cur_line);
      if (rem_dec)  rem_q    <= rem_q - line_t'(1);
    end
  end

  assign at_last = (rem_q == '0);

  // R3: the span counter is never stepped below its last line
  a_r3_no_step_past_last: assert property (@(posedge clk) disable iff (rst)
    rem_dec |-> !at_last);
endmodule

// File: rtl/xfer_ctrl_fsm.sv
`timescale 1ns/1ps
module xfer_ctrl_fsm
  import xfer_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        cmd_take,
  input  xfer_op_e    op,
  input  logic        rd_take_last,
  input  logic        rd_finish,
  input  logic        rd_abort,
  input  logic        wr_take_last,
  input  logic        wr_finish,
  input  logic        wr_abort,
  output xfer_state_e st
);
  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE;
    end else if (cmd_take) begin
      case (op)
        OP_CLEAR: st <= ST_IDLE;
        OP_READ:  st <= ST_PRE_READ;
        OP_WRITE: st <= ST_WRITING;
        default:  st <= st;
      endcase
    end else begin
      case (st)
        ST_PRE_READ: begin
          if (rd_abort)       st <= ST_ERROR;
          else if (rd_finish) st <= ST_DONE;
          else                st <= ST_READING;
        end
        ST_READING: begin
          if (rd_abort)                       st <= ST_ERROR;
          else if (rd_finish || rd_take_last) st <= ST_DONE;
        end
        ST_WRITING: begin
          if (wr_abort)                       st <= ST_ERROR;
          else if (wr_finish || wr_take_last) st <= ST_DONE;
        end
        default: st <= st;
      endcase
    end
  end

  // R9: an abort from the active reader always lands in the error state
  a_r9_read_abort_errors: assert property (@(posedge clk) disable iff (rst)
    (st == ST_READING && rd_abort && !cmd_take) |=> (st == ST_ERROR));
  // R9: same for the writer
  a_r9_write_abort_errors: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WRITING && wr_abort && !cmd_take) |=> (st == ST_ERROR));
endmodule

// File: rtl/ram_stream_xfer.sv
`timescale 1ns/1ps
module ram_stream_xfer
  import xfer_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CMD_W-1:0]  cmd_word,
  input  logic              cmd_go,
  output logic              xfer_done,
  output logic              xfer_err,
  output logic              mem_en,
  output logic              mem_we,
  output logic [LINE_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_strobe,
  input  logic              wr_finish,
  input  logic              wr_abort,
  output logic              wr_ready,
  output logic              wr_full,
  output logic [DATA_W-1:0] rd_data,
  input  logic              rd_strobe,
  input  logic              rd_finish,
  input  logic              rd_abort,
  output logic              rd_sop,
  output logic              rd_eop
);
  xfer_cmd_t   cmd;
  logic        cmd_take;
  xfer_state_e st;
  line_t       cur_line;
  logic        at_last;
  logic        sop_pend_q;
  logic        full_q;

  xfer_cmd_decode u_decode (
    .cmd_word (cmd_word),
    .cmd_go   (cmd_go),
    .cmd      (cmd),
    .cmd_take (cmd_take)
  );

  // named internal events, shared by the datapath and the assertions
  logic in_pre, in_rd, in_wr;
  logic ev_load, ev_rd_take, ev_rd_adv, ev_fetch, ev_wr_take, ev_wr_last;
  assign in_pre     = (st == ST_PRE_READ);
  assign in_rd      = (st == ST_READING);
  assign in_wr      = (st == ST_WRITING);
  assign ev_load    = cmd_take && (cmd.op == OP_READ || cmd.op == OP_WRITE);
  assign ev_rd_take = in_rd && rd_strobe && !cmd_take;
  assign ev_rd_adv  = ev_rd_take && !at_last && !rd_finish && !rd_abort;
  assign ev_fetch   = (in_pre && !cmd_take) || ev_rd_adv;
  assign ev_wr_take = in_wr && wr_strobe && !cmd_take;
  assign ev_wr_last = ev_wr_take && at_last;

  xfer_line_walker u_walker (
    .clk        (clk),
    .rst        (rst),
    .load       (ev_load),
    .load_first (cmd.first),
    .load_last  (cmd.last),
    .addr_inc   (ev_fetch || (ev_wr_take && !at_last)),
    .rem_dec    (ev_rd_adv || (ev_wr_take && !at_last)),
    .cur_line   (cur_line),
    .at_last    (at_last)
  );

  xfer_ctrl_fsm u_fsm (
    .clk          (clk),
    .rst          (rst),
    .cmd_take     (cmd_take),
    .op           (cmd.op),
    .rd_take_last (ev_rd_take && at_last),
    .rd_finish    (rd_finish),
    .rd_abort     (rd_abort),
    .wr_take_last (ev_wr_last),
    .wr_finish    (wr_finish),
    .wr_abort     (wr_abort),
    .st           (st)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sop_pend_q <= 1'b0;
      full_q     <= 1'b0;
    end else begin
      if (cmd_take)        sop_pend_q <= 1'b0;
      else if (in_pre)     sop_pend_q <= 1'b1;
      else if (ev_rd_take) sop_pend_q <= 1'b0;

      if (cmd_take)                     full_q <= 1'b0;
      else if (ev_wr_last && !wr_abort) full_q <= 1'b1;
    end
  end

  assign mem_en    = ev_fetch || ev_wr_take;
  assign mem_we    = ev_wr_take;
  assign mem_addr  = cur_line;
  assign mem_wdata = wr_data;
  assign rd_data   = mem_rdata;
  assign rd_sop    = in_rd && sop_pend_q;
  assign rd_eop    = in_rd && at_last;
  assign wr_ready  = in_wr;
  assign wr_full   = full_q;
  assign xfer_done = (st == ST_DONE);
  assign xfer_err  = (st == ST_ERROR);

  // R5: no RAM traffic while the consumer is idling
  a_r5_wait_no_access: assert property (@(posedge clk) disable iff (rst)
    (in_rd && !rd_strobe) |-> !mem_en);
  // R6: RAM writes only come from an accepted producer strobe
  a_r6_write_needs_ready: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (wr_ready && wr_strobe));
  // R10: once a transfer has ended the RAM is left alone
  a_r10_quiet_after_end: assert property (@(posedge clk) disable iff (rst)
    (xfer_done || xfer_err) |-> !mem_en);
  // R9: the two end reports never coincide
  a_r9_end_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(xfer_done && xfer_err));
  // R7: full is only reported for a transfer that completed
  a_r7_full_implies_done: assert property (@(posedge clk) disable iff (rst)
    wr_full |-> xfer_done);
  // R4: start-of-packet drops once the first line is taken
  a_r4_sop_once: assert property (@(posedge clk) disable iff (rst)
    (rd_sop && rd_strobe) |=> !rd_sop);
  // R11: a clear command idles every status output
  a_r11_clear_idles: assert property (@(posedge clk) disable iff (rst)
    (cmd_go && cmd_word[B_CLEAR]) |=> (!xfer_done && !xfer_err && !wr_ready && !wr_full && !rd_sop));
  // R1: nothing is driven toward the RAM in the cycle after reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> !mem_en);
endmodule

// File: tb/ram_stream_xfer_tb.sv
`timescale 1ns/1ps
module ram_stream_xfer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] cmd_word = '0;
  logic        cmd_go = 1'b0;
  logic        xfer_done, xfer_err, mem_en, mem_we, wr_ready, wr_full, rd_sop, rd_eop;
  logic [8:0]  mem_addr;
  logic [31:0] mem_wdata, rd_data;
  logic [31:0] mem_rdata = '0;
  logic [31:0] wr_data = '0;
  logic        wr_strobe = 0, wr_finish = 0, wr_abort = 0;
  logic        rd_strobe = 0, rd_finish = 0, rd_abort = 0;

  always #2.5 clk = ~clk;

  ram_stream_xfer u_dut (
    .clk(clk), .rst(rst), .cmd_word(cmd_word), .cmd_go(cmd_go),
    .xfer_done(xfer_done), .xfer_err(xfer_err),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .wr_data(wr_data), .wr_strobe(wr_strobe), .wr_finish(wr_finish), .wr_abort(wr_abort),
    .wr_ready(wr_ready), .wr_full(wr_full),
    .rd_data(rd_data), .rd_strobe(rd_strobe), .rd_finish(rd_finish), .rd_abort(rd_abort),
    .rd_sop(rd_sop), .rd_eop(rd_eop)
  );

  logic [31:0] ram [512];
  logic [31:0] shadow [512];
  int acc = 0;
  int checks = 0;
  int bad = 0;
  int cyc = 0;

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) ram[mem_addr] <= mem_wdata;
      else        mem_rdata <= ram[mem_addr];
      acc <= acc + 1;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      checks++;
      bad++;
      $display("FAIL watchdog (R1..): actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // span length written as two cases instead of a modular subtraction
  function automatic int span_len(int f, int l);
    if (l >= f) return l - f + 1;
    return (512 - f) + l + 1;
  endfunction

  task automatic issue(input bit clr, input bit rd, input bit wr, input int f, input int l);
    @(negedge clk);
    cmd_word = {7'd0, clr, wr, rd, 4'd0, 9'(l), 9'(f)};
    cmd_go = 1'b1;
    @(negedge clk);
    cmd_go = 1'b0;
  endtask

  task automatic end_checks(input string req, input int s, input int cnt, input int n, input int endmode, input int endidx);
    bit hit_end;
    hit_end = (endmode != 0) && (endidx < n) && (endidx < cnt);
    check(req, "xfer_err", 32'(xfer_err), 32'(hit_end && endmode == 2));
    check(req, "xfer_done", 32'(xfer_done),
          32'(!(hit_end && endmode == 2) && (s == cnt || (hit_end && endmode == 1))));
  endtask

  task automatic run_read(input string req, input int f, input int l, input int n,
                          input int waits, input int endmode, input int endidx);
    int cnt, s, a0, expacc;
    bit ended, live;
    cnt = span_len(f, l);
    s = 0;
    ended = 0;
    issue(0, 1, 0, f, l);
    a0 = acc;
    @(negedge clk);
    for (int k = 0; k < n; k++) begin
      live = !ended && (k < cnt);
      if (live) begin
        check(req, "rd_data", rd_data, shadow[(f + k) % 512]);
        check("R4", "rd_sop", 32'(rd_sop), 32'(k == 0));
        check("R4", "rd_eop", 32'(rd_eop), 32'(k == cnt - 1));
        s++;
      end
      rd_strobe = 1'b1;
      if (endmode != 0 && k == endidx) begin
        rd_finish = (endmode == 1);
        rd_abort  = (endmode == 2);
        ended = 1;
      end
      @(negedge clk);
      rd_strobe = 0; rd_finish = 0; rd_abort = 0;
      for (int w = 0; w < waits; w++) begin
        if (!ended && k + 1 < cnt)
          check("R5", "held rd_data", rd_data, shadow[(f + k + 1) % 512]);
        @(negedge clk);
      end
    end
    if (s == cnt) expacc = cnt;
    else if (ended) expacc = s;
    else expacc = s + 1;
    check("R10", "read access count", 32'(acc - a0), 32'(expacc));
    end_checks(req, s, cnt, n, endmode, endidx);
  endtask

  task automatic run_write(input string req, input int f, input int l, input int n,
                           input int endmode, input int endidx, input logic [31:0] base);
    int cnt, s, a0, mm;
    bit ended, live;
    cnt = span_len(f, l);
    s = 0;
    ended = 0;
    issue(0, 0, 1, f, l);
    a0 = acc;
    for (int k = 0; k < n; k++) begin
      live = !ended && (k < cnt);
      if (live) begin
        check("R6", "wr_ready", 32'(wr_ready), 32'd1);
        shadow[(f + k) % 512] = base + 32'(k);
        s++;
      end
      wr_data = base + 32'(k);
      wr_strobe = 1'b1;
      if (endmode != 0 && k == endidx) begin
        wr_finish = (endmode == 1);
        wr_abort  = (endmode == 2);
        ended = 1;
      end
      @(negedge clk);
      wr_strobe = 0; wr_finish = 0; wr_abort = 0;
    end
    check("R10", "write access count", 32'(acc - a0), 32'(s));
    check("R7", "wr_full", 32'(wr_full), 32'(s == cnt));
    end_checks(req, s, cnt, n, endmode, endidx);
    mm = 0;
    for (int i = 0; i < 512; i++) if (ram[i] !== shadow[i]) mm++;
    check(req, "RAM lines differing from shadow", 32'(mm), 32'd0);
  endtask

  task automatic t_reset;
    check("R1", "xfer_done", 32'(xfer_done), 0);
    check("R1", "xfer_err", 32'(xfer_err), 0);
    check("R1", "wr_ready", 32'(wr_ready), 0);
    check("R1", "wr_full", 32'(wr_full), 0);
    check("R1", "rd_sop/eop", {30'd0, rd_sop, rd_eop}, 0);
    check("R1", "mem_en", 32'(mem_en), 0);
  endtask

  task automatic t_command_gate;
    int a0;
    a0 = acc;
    @(negedge clk);
    cmd_word = {7'd0, 1'b0, 1'b1, 1'b0, 4'd0, 9'd3, 9'd1};
    repeat (3) @(negedge clk);
    check("R2", "wr_ready without go", 32'(wr_ready), 0);
    check("R2", "accesses without go", 32'(acc - a0), 0);
    issue(0, 1, 1, 20, 22);
    @(negedge clk);
    check("R2", "read wins rd_sop", 32'(rd_sop), 1);
    check("R2", "read wins wr_ready", 32'(wr_ready), 0);
    issue(1, 1, 0, 20, 22);
    check("R2", "clear wins rd_sop", 32'(rd_sop), 0);
    check("R2", "clear wins done", 32'(xfer_done), 0);
  endtask

  task automatic t_clear_checks(input string what);
    issue(1, 0, 0, 0, 0);
    check("R11", {what, " xfer_done"}, 32'(xfer_done), 0);
    check("R11", {what, " xfer_err"}, 32'(xfer_err), 0);
    check("R11", {what, " wr_ready"}, 32'(wr_ready), 0);
    check("R11", {what, " wr_full"}, 32'(wr_full), 0);
    check("R11", {what, " rd_sop"}, 32'(rd_sop), 0);
  endtask

  task automatic t_done_holds;
    run_write("R7", 100, 103, 4, 0, 0, 32'h7000_0000);
    repeat (5) @(negedge clk);
    check("R7", "done after idle", 32'(xfer_done), 1);
    check("R7", "full after idle", 32'(wr_full), 1);
    t_clear_checks("after full");
  endtask

  initial begin
    for (int i = 0; i < 512; i++) begin
      ram[i] = 32'hC0DE_0000 | 32'(i);
      shadow[i] = 32'hC0DE_0000 | 32'(i);
    end
    repeat (4) @(negedge clk);
    t_reset;
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_command_gate;

    run_read("R4", 5, 10, 6, 0, 0, 0);
    run_read("R5", 5, 10, 6, 2, 0, 0);
    run_read("R3", 505, 3, 11, 0, 0, 0);
    run_read("R3", 7, 7, 1, 1, 0, 0);
    run_read("R3", 0, 511, 512, 0, 0, 0);
    run_read("R8", 5, 10, 6, 0, 1, 2);
    run_read("R9", 5, 10, 4, 3, 2, 1);
    run_read("R10", 5, 10, 9, 1, 0, 0);
    run_read("R4", 5, 10, 3, 0, 0, 0);
    t_clear_checks("mid read");

    run_write("R6", 10, 15, 6, 0, 0, 32'h1000_0000);
    run_write("R3", 508, 4, 9, 0, 0, 32'h2000_0000);
    run_write("R10", 40, 45, 10, 0, 0, 32'h3000_0000);
    run_write("R8", 60, 70, 6, 1, 5, 32'h4000_0000);
    run_write("R9", 80, 90, 4, 2, 3, 32'h5000_0000);
    run_write("R6", 120, 130, 3, 0, 0, 32'h6000_0000);
    t_clear_checks("mid write");
    run_read("R6", 506, 10, 17, 0, 0, 0);
    run_read("R10", 38, 47, 10, 0, 0, 0);
    t_done_holds;

    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule